// File: doc/BRIEF.md
# Dual-Space I2C Target with Row-Wrapping Writes

This block is an I2C bus target that fronts two byte-wide register memories: an auxiliary space at a fixed bus address and a main space whose bus address is partly set by pins. The system clock oversamples SCL and SDA through a synchronizer. The block drives SDA only as an open-drain pull-down enable. After a START, the first byte selects a space and a direction. In a write, the next byte loads an internal memory pointer, and each later byte is stored at that pointer. In a read, bytes stream out from the pointer for as long as the controller acknowledges them.

Writes stay inside one 8-byte row. The low three pointer bits wrap and the upper bits hold, so a burst longer than a row overwrites the start of the same row. Reads step through the whole 8-bit space with no wrapping. A repeated START after the memory-address byte turns the transaction into a read from that address.

The bus is the only data path, so the block has no valid/ready stream port. The bus controller owns all timing, and the target never holds SCL low. The address-select pins are static control inputs.

Top module: `i2cpw_target`

## Requirements
- R1: Every bus byte is received most significant bit first, one bit sampled on each rising edge of SCL. The target acknowledges a byte it accepts by driving SDA low (sda_oe = 1) for the whole 9th clock.
- R2: The auxiliary space answers to address byte A0h (write) / A1h (read). It does not answer when main_sel = 3'b000, which programs the main address byte to A0h or B0h. This holds whatever main_en is.
- R3: The main space answers only when main_en = 1. Its address byte is {3'b101, main_bank_hi, main_sel[2:0], R/W}, which gives A0h–AEh when main_bank_hi = 0 and B0h–BEh when main_bank_hi = 1. Its storage is separate from the auxiliary space.
- R4: When the address byte matches neither space, the target acknowledges nothing (SDA stays released on every 9th clock) and stores nothing until the next START.
- R5: In a write, the byte after the address byte is the memory address. Each following data byte is acknowledged and stored at the pointer, and the pointer then advances.
- R6: The write pointer wraps inside its 8-byte row: bits 2:0 count modulo 8 and bits 7:3 stay fixed. Three bytes written from 06h land at 06h, 07h and 00h. Nine bytes written from 28h leave the ninth byte at 28h.
- R7: A read returns the byte at the pointer. Each further byte comes from the next address across the full 8-bit space, so 07h is followed by 08h. The target changes SDA only while SCL is low.
- R8: An ACK (SDA low) from the controller on the 9th clock of a read byte makes the target drive the next byte. A NACK makes it release SDA and ignore the bus until the next START.
- R9: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are recognized in any state. A repeated START after the memory address keeps the pointer, so a read begins there. STOP releases SDA.
- R10: After reset, sda_oe is 0 and every memory byte reads as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| main_sel | input | 3 | Programmable bits 3:1 of the main address byte |
| main_bank_hi | input | 1 | Selects the B0h-based (1) or A0h-based (0) main range |
| main_en | input | 1 | Enables the main address space |

## Verification
The checks on SDA timing assume that each SCL low and high phase lasts well beyond the synchronizer delay of about four system clocks. They also assume the controller moves SDA only while SCL is low, except for START and STOP. The bench bit-bangs the bus with quarter-bit phases of ten system clocks and changes its SDA drive only in the low phase. The address-select pins are changed only between transactions while the bus is idle, because the rule that blocks the auxiliary space is checked against their current value at each write.

// File: rtl/i2cpw_pkg.sv
package i2cpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_MADDR,
    PH_WDATA
  } byte_ph_t;

  localparam int SPACE_AUX  = 0;
  localparam int SPACE_MAIN = 1;
  localparam int NSPACE     = 2;
endpackage

// File: rtl/i2cpw_sync.sv
module i2cpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cpw_match.sv
module i2cpw_match #(
  parameter logic [6:0] AUX_DEV   = 7'h50,
  parameter logic [2:0] MAIN_BASE = 3'b101
) (
  input  logic [6:0] dev_addr,
  input  logic [2:0] main_sel,
  input  logic       main_bank_hi,
  input  logic       main_en,
  output logic       hit_aux,
  output logic       hit_main
);
  logic [6:0] main_dev;
  logic       aux_blocked;

  assign main_dev    = {MAIN_BASE, main_bank_hi, main_sel};
  // main byte equal to either bank's base blocks the auxiliary space
  assign aux_blocked = (main_sel == 3'b000);
  assign hit_main    = main_en && (dev_addr == main_dev);
  assign hit_aux     = !aux_blocked && (dev_addr == AUX_DEV);
endmodule

// File: rtl/i2cpw_regmem.sv
module i2cpw_regmem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2cpw_engine.sv
module i2cpw_engine
  import i2cpw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int ROW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit_aux,
  input  logic              hit_main,
  input  logic [7:0]        rd_aux,
  input  logic [7:0]        rd_main,
  output logic [6:0]        dev_addr,
  output logic [NSPACE-1:0] wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [7:0]        wr_data,
  output logic [AW-1:0]     ptr,
  output logic              sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  bus_st_t       st;
  byte_ph_t      ph;
  logic [3:0]    cnt;
  logic [7:0]    sreg, txreg;
  logic          tgt_main, rw;
  logic [7:0]    rd_byte;
  logic          byte_done;
  logic [AW-1:0] ptr_row_next;

  assign rd_byte      = tgt_main ? rd_main : rd_aux;
  assign byte_done    = (st == ST_RX) && scl_fall && (cnt == LAST_BIT);
  assign dev_addr     = sreg[7:1];
  assign wr_addr      = ptr;
  assign wr_data      = sreg;
  assign ptr_row_next = {ptr[AW-1:ROW_W], ptr[ROW_W-1:0] + 1'b1};

  always_comb begin
    wr_en = '0;
    if (byte_done && ph == PH_WDATA) begin
      wr_en[SPACE_MAIN] = tgt_main;
      wr_en[SPACE_AUX]  = !tgt_main;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_DEV;
      cnt      <= '0;
      sreg     <= '0;
      txreg    <= '0;
      tgt_main <= 1'b0;
      rw       <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      st     <= ST_RX;
      ph     <= PH_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && cnt < LAST_BIT) begin
            sreg <= {sreg[6:0], sda_s};
            cnt  <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            unique case (ph)
              PH_DEV: begin
                if (hit_aux || hit_main) begin
                  tgt_main <= hit_main;
                  rw       <= sreg[0];
                  sda_oe   <= 1'b1;
                  st       <= ST_RXACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_MADDR: begin
                ptr    <= sreg[AW-1:0];
                sda_oe <= 1'b1;
                st     <= ST_RXACK;
              end
              default: begin
                ptr    <= ptr_row_next;
                sda_oe <= 1'b1;
                st     <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            if (ph == PH_DEV && rw) begin
              st     <= ST_TX;
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              st     <= ST_RX;
              sda_oe <= 1'b0;
              ph     <= (ph == PH_DEV) ? PH_MADDR : PH_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_TXACK;
              ptr    <= ptr + 1'b1;
              cnt    <= '0;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            if (sda_s) st <= ST_IDLE;
          end else if (scl_fall) begin
            st     <= ST_TX;
            txreg  <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cpw_target.sv
module i2cpw_target
  import i2cpw_pkg::*;
#(
  parameter int AW          = 8,
  parameter int ROW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] main_sel,
  input  logic       main_bank_hi,
  input  logic       main_en
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              hit_aux, hit_main;
  logic [6:0]        dev_addr;
  logic [NSPACE-1:0] wr_en;
  logic [AW-1:0]     wr_addr, ptr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data [NSPACE];

  i2cpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cpw_match u_match (
    .dev_addr(dev_addr), .main_sel(main_sel), .main_bank_hi(main_bank_hi),
    .main_en(main_en), .hit_aux(hit_aux), .hit_main(hit_main)
  );

  i2cpw_engine #(.AW(AW), .ROW_W(ROW_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .hit_aux(hit_aux), .hit_main(hit_main),
    .rd_aux(rd_data[SPACE_AUX]), .rd_main(rd_data[SPACE_MAIN]),
    .dev_addr(dev_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ptr(ptr), .sda_oe(sda_oe)
  );

  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    i2cpw_regmem #(.AW(AW), .DW(8)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(wr_en[g]), .waddr(wr_addr),
      .wdata(wr_data), .raddr(ptr), .rdata(rd_data[g])
    );
  end
endmodule

// File: rtl/i2cpw_chk.sv
module i2cpw_chk #(
  parameter int AW    = 8,
  parameter int ROW_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          stop_det,
  input logic [1:0]    wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr,
  input logic [2:0]    main_sel
);
  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_release_chk: assert (!sda_oe);
    end
  end

  // R7
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |=> (ptr[AW-1:ROW_W] == $past(wr_addr[AW-1:ROW_W])));

  // R5
  one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R2
  aux_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |-> (main_sel != 3'b000));
endmodule

bind i2cpw_target i2cpw_chk #(.AW(AW), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr),
  .main_sel(main_sel)
);

// File: tb/tb_i2cpw_target.sv
module tb_i2cpw_target;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [2:0] main_sel = 3'b010;
  logic       main_bank_hi = 1'b0;
  logic       main_en = 1'b1;
  logic       sda_bus;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];
  logic [7:0] wd [10];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2cpw_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .main_sel(main_sel), .main_bank_hi(main_bank_hi), .main_en(main_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; qwait(); scl = 1'b1; qwait();
    s = sda_bus; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      v[i] = s;
    end
    bus_bit(~mack, s);
  endtask

  // write n bytes from wd[] to dev at addr; every byte must be acked
  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] addr, input int n, input string tag);
    logic a;
    bus_start();
    wbyte(dev, a);  check(a, {tag, " addr ack"}, a, 1);
    wbyte(addr, a); check(a, {tag, " maddr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wd[i], a);
      check(a, {tag, " data ack"}, a, 1);
    end
    bus_stop();
  endtask

  // read n bytes via repeated START; expected values go to the scoreboard
  task automatic rd_seq(input logic [7:0] dev, input logic [7:0] addr, input int n,
                        input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                        input string tag);
    logic a;
    logic [7:0] v;
    bus_start();
    wbyte(dev, a);         check(a, {tag, " R1 wr ack"}, a, 1);
    wbyte(addr, a);        check(a, {tag, " R5 maddr ack"}, a, 1);
    bus_start();
    wbyte(dev | 8'h01, a); check(a, {tag, " R9 rd ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i == 0 ? e0 : (i == 1 ? e1 : (i == 2 ? e2 : wd[i])));
      tag_q.push_back(tag);
      rbyte(i < n - 1, v);
      act_q.push_back(v);
    end
    // R8: after NACK the target has let go of SDA
    check(!sda_oe, "R8 release after NACK", sda_oe, 0);
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [7:0] got, want;
        string t;
        got  = act_q.pop_front();
        want = exp_q.pop_front();
        t    = tag_q.pop_front();
        check(got == want, t, got, want);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a, s;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    check(!sda_oe, "R10 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 R6: three bytes from 06h wrap to 00h; R7 read 06,07,08 with no wrap
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33;
    wr_seq(8'hA0, 8'h06, 3, "R5 aux write");
    rd_seq(8'hA0, 8'h06, 3, 8'h11, 8'h22, 8'h00, "R7 R10 aux read 06");
    rd_seq(8'hA0, 8'h00, 1, 8'h33, 8'h00, 8'h00, "R6 wrapped byte at 00");

    // R3: main space at A4h, separate storage
    wd[0] = 8'hAA; wd[1] = 8'hBB;
    wr_seq(8'hA4, 8'h10, 2, "R3 main write");
    rd_seq(8'hA4, 8'h10, 2, 8'hAA, 8'hBB, 8'h00, "R3 main read");
    rd_seq(8'hA0, 8'h10, 1, 8'h00, 8'h00, 8'h00, "R3 aux untouched");

    // R4: mismatch, nothing acked, nothing stored
    bus_start();
    wbyte(8'hC0, a); check(!a, "R4 mismatch addr nack", a, 0);
    wbyte(8'h06, a); check(!a, "R4 mismatch maddr nack", a, 0);
    wbyte(8'h77, a); check(!a, "R4 mismatch data nack", a, 0);
    bus_stop();
    rd_seq(8'hA0, 8'h06, 1, 8'h11, 8'h00, 8'h00, "R4 no store");

    // R3: disabled main space
    main_en = 1'b0;
    bus_start(); wbyte(8'hA4, a); bus_stop();
    check(!a, "R3 main disabled nack", a, 0);
    main_en = 1'b1;

    // R2: main programmed to A0h takes the address, aux blocked
    main_sel = 3'b000;
    wd[0] = 8'h5A;
    wr_seq(8'hA0, 8'h20, 1, "R2 main at A0");
    rd_seq(8'hA0, 8'h20, 1, 8'h5A, 8'h00, 8'h00, "R2 main at A0 read");
    main_sel = 3'b010;
    rd_seq(8'hA0, 8'h20, 1, 8'h00, 8'h00, 8'h00, "R2 aux was blocked");
    rd_seq(8'hA4, 8'h20, 1, 8'h5A, 8'h00, 8'h00, "R2 byte in main");

    // R2 R3: main at B0h disabled still blocks aux; enabled B0h answers
    main_sel = 3'b000; main_bank_hi = 1'b1; main_en = 1'b0;
    bus_start(); wbyte(8'hA0, a); bus_stop();
    check(!a, "R2 aux blocked by B0", a, 0);
    main_en = 1'b1;
    bus_start(); wbyte(8'hB0, a); bus_stop();
    check(a, "R3 bank B0 ack", a, 1);
    main_sel = 3'b010; main_bank_hi = 1'b0;

    // R6: nine bytes from 28h, ninth overwrites 28h
    for (int i = 0; i < 9; i++) wd[i] = 8'(i + 1);
    wr_seq(8'hA0, 8'h28, 9, "R6 nine byte write");
    wd[0] = 8'h09; wd[1] = 8'h02; wd[2] = 8'h03;
    for (int i = 3; i < 8; i++) wd[i] = 8'(i + 1);
    rd_seq(8'hA0, 8'h28, 8, 8'h09, 8'h02, 8'h03, "R6 row wrap read");

    // R8: master ACK keeps the target driving the next byte (22h at 07h, MSB 0)
    bus_start();
    wbyte(8'hA0, a); wbyte(8'h06, a);
    bus_start();
    wbyte(8'hA1, a);
    rbyte(1'b1, v);
    check(v == 8'h11, "R8 first byte", v, 8'h11);
    qwait();
    check(sda_oe, "R8 drives next after ACK", sda_oe, 1);
    rbyte(1'b0, v);
    check(v == 8'h22, "R8 second byte", v, 8'h22);
    bus_stop();
    // R8: after NACK the bus is ignored until START
    bus_bit(1'b1, s);
    check(!sda_oe, "R8 idle after NACK", sda_oe, 0);

    wait (act_q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule